// File: doc/BRIEF.md
# Clock Register Access Sequencer

This block turns already-decoded serial bus events (transaction start with a direction, transaction stop, an address phase and per-byte read or write strobes) into accesses to a small 64-location clock/control register space. The space is split into sections: two alarm banks, a control bank, a time bank and a single status register. A transfer may begin at any address. Consecutive bytes advance an address pointer that wraps to the first location of the section it is in, so a burst never leaves its section. The pointer persists between transactions, so a read with no address phase continues where the last transfer stopped.

The time bank is not stored here. The external timekeeper presents its live value on `live_time`. At every transaction start the block copies that value into one shared holding buffer. A read transaction returns time bytes from this frozen copy, so a counter tick during the burst cannot tear the result. A write transaction edits the copy and hands the whole updated time back on `time_load`/`time_data` only when the transaction ends. The status register takes exactly one byte per transaction and is always writable. Every other section is writable only while two enable bits in the status register are both set.

Top module: `clkreg_seq`

## Requirements
- R1: Each byte performed advances the pointer by one, except at the last location of a section, where it returns to that section's first location. The sections are alarm A 0x00-0x07, alarm B 0x08-0x0F, control 0x10-0x13 and time 0x30-0x37.
- R2: An address phase (`addr_load`) sets the pointer, and the next byte of the transaction is performed at that address, whichever location in the space it is.
- R3: The status register at 0x3F accepts a single byte per transaction. A further read or write strobe in the same transaction is not performed: no `rd_valid`, no register change. Strobes are then ignored until the next start.
- R4: Writes to 0x3F are always accepted. Writes to the alarm, control and time sections take effect only while status bits 1 and 2 are both 1.
- R5: Every transaction start copies `live_time` into the holding buffer. Time bytes read in that transaction come from the copy (byte k of `live_time`, bits 8k+7:8k, is address 0x30+k), even if `live_time` changes meanwhile.
- R6: Time bytes written land in the holding buffer only. When a transaction that wrote at least one time byte ends by stop or repeated start, `time_load` pulses for one cycle, one cycle after that event. It carries `time_data` equal to the copy taken at start with the written bytes replaced. Without a time write, `time_load` stays low.
- R7: After a transaction, the pointer holds the address after the last byte performed, following R1. A read with no address phase returns that register.
- R8: Addresses 0x05, 0x0D and 0x11, and every address in no section, read as 0x00 and ignore writes.
- R9: `rd_valid` rises for one cycle, one cycle after a `rd_stb` that is performed, with `rd_data` holding the byte. `rd_stb` in a write transaction and `wr_stb` in a read transaction are ignored.
- R10: After reset, all stored registers read 0x00, the pointer is 0x00, and `rd_valid` and `time_load` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Start or repeated start of a transaction |
| txn_read | input | 1 | Direction with `txn_start`: 1 read, 0 write |
| txn_stop | input | 1 | End of transaction |
| addr_load | input | 1 | Address phase strobe |
| addr_in | input | 6 | Register address for the address phase |
| wr_stb | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_stb | input | 1 | Read byte request |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` valid for this cycle |
| live_time | input | 64 | Live time value, byte k at address 0x30+k |
| time_load | output | 1 | One-cycle request to load `time_data` into the timekeeper |
| time_data | output | 64 | Updated time value |

## Verification
Bursts start in the middle of each section and run past its end. This separates per-section wrapping from a plain increment and shows that hole locations read zero while the burst continues. The live time is changed in the middle of a read burst and again before a write, which tells a frozen copy apart from a live read and shows that a commit merges written bytes into the copy taken at start. The same byte patterns are sent while locked and unlocked, to the status register twice in one transaction, and with the wrong strobe for the direction. Each of these must leave the state untouched, and a following read shows it.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    localparam int ADDR_W      = 6;
    localparam int DATA_W      = 8;
    localparam int ALARM_BYTES = 8;
    localparam int CTL_BYTES   = 4;
    localparam int TIME_BYTES  = 8;
    localparam int TIDX_W      = $clog2(TIME_BYTES);
    localparam int RF_DEPTH    = 2 * ALARM_BYTES + CTL_BYTES;
    localparam int ALARM_HOLE  = 5;
    localparam int CTL_HOLE    = 1;
    localparam int UNLOCK_LO   = 1;
    localparam int UNLOCK_HI   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t AL0_BASE  = addr_t'('h00);
    localparam addr_t AL1_BASE  = addr_t'('h08);
    localparam addr_t CTL_BASE  = addr_t'('h10);
    localparam addr_t TIME_BASE = addr_t'('h30);
    localparam addr_t STAT_ADDR = addr_t'('h3F);
    localparam addr_t AL0_LAST  = AL0_BASE  + addr_t'(ALARM_BYTES - 1);
    localparam addr_t AL1_LAST  = AL1_BASE  + addr_t'(ALARM_BYTES - 1);
    localparam addr_t CTL_LAST  = CTL_BASE  + addr_t'(CTL_BYTES - 1);
    localparam addr_t TIME_LAST = TIME_BASE + addr_t'(TIME_BYTES - 1);

    typedef enum logic [2:0] {
        SEC_NONE, SEC_AL0, SEC_AL1, SEC_CTL, SEC_TIME, SEC_STAT
    } sec_e;

    typedef enum logic [1:0] {TX_IDLE, TX_ACTIVE, TX_HALT} tx_e;

    typedef struct packed {
        tx_e  st;
        logic is_rd;
        logic stat_done;
    } txn_t;

    function automatic sec_e sec_of(addr_t a);
        if (a >= AL0_BASE && a <= AL0_LAST)        return SEC_AL0;
        else if (a >= AL1_BASE && a <= AL1_LAST)   return SEC_AL1;
        else if (a >= CTL_BASE && a <= CTL_LAST)   return SEC_CTL;
        else if (a >= TIME_BASE && a <= TIME_LAST) return SEC_TIME;
        else if (a == STAT_ADDR)                   return SEC_STAT;
        return SEC_NONE;
    endfunction

    function automatic addr_t sec_base(sec_e s);
        case (s)
            SEC_AL0:  return AL0_BASE;
            SEC_AL1:  return AL1_BASE;
            SEC_CTL:  return CTL_BASE;
            SEC_TIME: return TIME_BASE;
            default:  return STAT_ADDR;
        endcase
    endfunction

    function automatic addr_t sec_last(sec_e s);
        case (s)
            SEC_AL0:  return AL0_LAST;
            SEC_AL1:  return AL1_LAST;
            SEC_CTL:  return CTL_LAST;
            SEC_TIME: return TIME_LAST;
            default:  return STAT_ADDR;
        endcase
    endfunction

    function automatic logic is_hole(addr_t a);
        return (a == AL0_BASE + addr_t'(ALARM_HOLE)) ||
               (a == AL1_BASE + addr_t'(ALARM_HOLE)) ||
               (a == CTL_BASE + addr_t'(CTL_HOLE));
    endfunction

    // Step inside the section; outside any section a plain increment.
    function automatic addr_t next_addr(addr_t a);
        sec_e s;
        s = sec_of(a);
        if (s == SEC_NONE)    return a + addr_t'(1);
        if (a == sec_last(s)) return sec_base(s);
        return a + addr_t'(1);
    endfunction

endpackage

// File: rtl/clkreg_ptr.sv
module clkreg_ptr
    import clkreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  addr_t load_addr,
    input  logic  adv,
    output addr_t ptr
);

    sec_e cur_sec;
    assign cur_sec = sec_of(ptr);

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (load) ptr <= load_addr;
        else if (adv)  ptr <= next_addr(ptr);
    end

    // R1: a burst never leaves the section it is in
    assert_stay_in_section_R1: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && cur_sec != SEC_NONE) |=> (cur_sec == $past(cur_sec)));

endmodule

// File: rtl/clkreg_regfile.sv
module clkreg_regfile
    import clkreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t addr,
    input  byte_t wr_data,
    output byte_t rd_data,
    output logic  unlocked
);

    byte_t store [RF_DEPTH];
    byte_t status_q;
    sec_e  sec;
    logic  in_bank;
    int    idx;

    assign sec      = sec_of(addr);
    assign in_bank  = (sec == SEC_AL0) || (sec == SEC_AL1) || (sec == SEC_CTL);
    assign unlocked = status_q[UNLOCK_LO] && status_q[UNLOCK_HI];

    always_comb begin
        if (sec == SEC_CTL) idx = 2 * ALARM_BYTES + int'(addr - CTL_BASE);
        else                idx = int'(addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            for (int i = 0; i < RF_DEPTH; i++) store[i] <= '0;
        end else if (wr_en) begin
            if (sec == SEC_STAT) status_q <= wr_data;
            for (int i = 0; i < RF_DEPTH; i++)
                if (in_bank && idx == i) store[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (sec == SEC_STAT) rd_data = status_q;
        for (int i = 0; i < RF_DEPTH; i++)
            if (in_bank && idx == i) rd_data = store[i];
    end

    // R4: the sequencer only writes a locked bank through the status register
    assert_locked_write_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (unlocked || sec == SEC_STAT));

endmodule

// File: rtl/clkreg_time_buf.sv
module clkreg_time_buf
    import clkreg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            capture,
    input  logic [TIME_BYTES*DATA_W-1:0]    live,
    input  logic                            wr_en,
    input  logic [TIDX_W-1:0]               wr_idx,
    input  byte_t                           wr_data,
    input  logic                            commit,
    output logic [TIME_BYTES-1:0][DATA_W-1:0] tbuf,
    output logic                            time_load,
    output logic [TIME_BYTES*DATA_W-1:0]    time_data
);

    logic [TIME_BYTES-1:0][DATA_W-1:0] tb_nxt;
    logic dirty;

    for (genvar g = 0; g < TIME_BYTES; g++) begin : g_byte
        assign tb_nxt[g] = capture ? live[g*DATA_W +: DATA_W] :
                           (wr_en && wr_idx == TIDX_W'(g)) ? wr_data : tbuf[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbuf      <= '0;
            dirty     <= 1'b0;
            time_load <= 1'b0;
            time_data <= '0;
        end else begin
            tbuf      <= tb_nxt;
            time_load <= commit && dirty;
            if (commit && dirty) time_data <= tbuf;
            if (commit)          dirty <= 1'b0;
            else if (wr_en)      dirty <= 1'b1;
        end
    end

endmodule

// File: rtl/clkreg_seq.sv
module clkreg_seq
    import clkreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        txn_start,
    input  logic        txn_read,
    input  logic        txn_stop,
    input  logic        addr_load,
    input  logic [5:0]  addr_in,
    input  logic        wr_stb,
    input  logic [7:0]  wr_data,
    input  logic        rd_stb,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic [63:0] live_time,
    output logic        time_load,
    output logic [63:0] time_data
);

    txn_t  tx;
    addr_t ptr;
    sec_e  cur_sec;
    logic  hole, byte_req, stat_block, busy_edge, go, halt_now;
    logic  unlocked, wr_ok, rf_we, tb_we, rd_go;
    byte_t rf_rd, rd_mux;
    logic [TIDX_W-1:0] tidx;
    logic [TIME_BYTES-1:0][DATA_W-1:0] tbuf;

    assign cur_sec    = sec_of(ptr);
    assign hole       = is_hole(ptr);
    assign tidx       = TIDX_W'(ptr - TIME_BASE);
    assign byte_req   = (rd_stb && tx.is_rd) || (wr_stb && !tx.is_rd);
    assign busy_edge  = txn_start || txn_stop;
    assign stat_block = (cur_sec == SEC_STAT) && tx.stat_done;
    assign go         = (tx.st == TX_ACTIVE) && byte_req && !busy_edge && !stat_block;
    assign halt_now   = (tx.st == TX_ACTIVE) && byte_req && !busy_edge && stat_block;
    assign rd_go      = go && tx.is_rd;
    assign wr_ok      = go && !tx.is_rd && cur_sec != SEC_NONE && !hole &&
                        (cur_sec == SEC_STAT || unlocked);
    assign rf_we      = wr_ok && cur_sec != SEC_TIME;
    assign tb_we      = wr_ok && cur_sec == SEC_TIME;

    clkreg_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (addr_load),
        .load_addr (addr_in),
        .adv       (go),
        .ptr       (ptr)
    );

    clkreg_regfile u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rf_we),
        .addr     (ptr),
        .wr_data  (wr_data),
        .rd_data  (rf_rd),
        .unlocked (unlocked)
    );

    clkreg_time_buf u_tb (
        .clk       (clk),
        .rst       (rst),
        .capture   (txn_start),
        .live      (live_time),
        .wr_en     (tb_we),
        .wr_idx    (tidx),
        .wr_data   (wr_data),
        .commit    (busy_edge),
        .tbuf      (tbuf),
        .time_load (time_load),
        .time_data (time_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '{st: TX_IDLE, is_rd: 1'b0, stat_done: 1'b0};
        end else if (txn_start) begin
            tx <= '{st: TX_ACTIVE, is_rd: txn_read, stat_done: 1'b0};
        end else if (txn_stop) begin
            tx.st <= TX_IDLE;
        end else if (halt_now) begin
            tx.st <= TX_HALT;
        end else if (go && cur_sec == SEC_STAT) begin
            tx.stat_done <= 1'b1;
        end
    end

    always_comb begin
        case (cur_sec)
            SEC_TIME: rd_mux = tbuf[tidx];
            SEC_NONE: rd_mux = '0;
            default:  rd_mux = hole ? '0 : rf_rd;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= rd_mux;
        end
    end

    // R3: once halted on the status register nothing more is returned
    assert_halt_silent_R3: assert property (@(posedge clk) disable iff (rst)
        (tx.st == TX_HALT) |=> !rd_valid);

    // R5: inside a read transaction the frozen copy does not move
    assert_snapshot_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx.st == TX_ACTIVE && tx.is_rd && !txn_start) |=> $stable(tbuf));

    // R6: a time update only follows the end of a transaction
    assert_commit_edge_R6: assert property (@(posedge clk) disable iff (rst)
        time_load |-> $past(txn_stop || txn_start));

    // R9: every returned byte answers a read strobe
    assert_read_cause_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_stb));

endmodule

// File: tb/clkreg_seq_test.sv
module clkreg_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_start = 1'b0, txn_read = 1'b0, txn_stop = 1'b0;
    logic        addr_load = 1'b0;
    logic [5:0]  addr_in = '0;
    logic        wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [63:0] live_time = '0;
    logic        time_load;
    logic [63:0] time_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    clkreg_seq uut (
        .clk(clk), .rst(rst), .txn_start(txn_start), .txn_read(txn_read),
        .txn_stop(txn_stop), .addr_load(addr_load), .addr_in(addr_in),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
        .rd_valid(rd_valid), .live_time(live_time), .time_load(time_load),
        .time_data(time_data)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard whenever a byte comes back
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected byte", 64'(rd_data), 64'hx);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data == e, t, 64'(rd_data), 64'(e));
            end
        end
    end

    task automatic start(input logic rd);
        @(negedge clk); txn_start = 1'b1; txn_read = rd;
        @(negedge clk); txn_start = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk); txn_stop = 1'b1;
        @(negedge clk); txn_stop = 1'b0;
    endtask

    task automatic set_addr(input logic [5:0] a);
        @(negedge clk); addr_load = 1'b1; addr_in = a;
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rbyte(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic rbyte_none(input string tag);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        check(rd_valid == 1'b0, tag, 64'(rd_valid), 64'd0);
    endtask

    task automatic stop_chk(input logic el, input logic [63:0] ed, input string tag);
        stop();
        check(time_load == el, tag, 64'(time_load), 64'(el));
        if (el) check(time_data == ed, tag, time_data, ed);
        @(negedge clk);
        check(time_load == 1'b0, tag, 64'(time_load), 64'd0);
    endtask

    localparam logic [63:0] T1 = 64'h0807_0605_0403_0201;
    localparam logic [63:0] T2 = 64'h1817_1615_1413_1211;

    initial begin : wdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(rd_valid == 1'b0, "R10 rd_valid", 64'(rd_valid), 64'd0);
        check(time_load == 1'b0, "R10 time_load", 64'(time_load), 64'd0);
        start(1'b1); rbyte(8'h00, "R10 reg 0x00 after reset"); stop();

        // R4: locked writes to a bank and to time are dropped
        start(1'b0); set_addr(6'h02); wbyte(8'hAA);
        set_addr(6'h32); wbyte(8'h99);
        stop_chk(1'b0, 64'd0, "R4 locked time write");
        start(1'b1); set_addr(6'h02); rbyte(8'h00, "R4 locked alarm write"); stop();

        // R3 + R4: status written without unlock; second byte dropped
        start(1'b0); set_addr(6'h3F); wbyte(8'h06); wbyte(8'hFF); stop();
        start(1'b1); set_addr(6'h3F);
        rbyte(8'h06, "R4 status write");
        rbyte_none("R3 second status byte");
        stop();

        // R1 + R2: alarm A burst from 0x06 wraps to 0x00
        start(1'b0); set_addr(6'h06);
        wbyte(8'h11); wbyte(8'h22); wbyte(8'h33); wbyte(8'h5C); stop();
        start(1'b1); set_addr(6'h06);
        rbyte(8'h11, "R2 start mid section");
        rbyte(8'h22, "R1 alarm A last");
        rbyte(8'h33, "R1 alarm A wrap");
        stop();
        // R7: current-address read continues at 0x01
        start(1'b1); rbyte(8'h5C, "R7 current address"); stop();

        // R1 + R8: control bank with hole at 0x11
        start(1'b0); set_addr(6'h10);
        wbyte(8'hA0); wbyte(8'hA1); wbyte(8'hA2); wbyte(8'hA3); stop();
        start(1'b1); set_addr(6'h10);
        rbyte(8'hA0, "R1 control first");
        rbyte(8'h00, "R8 control hole");
        rbyte(8'hA2, "R1 control");
        rbyte(8'hA3, "R1 control last");
        rbyte(8'hA0, "R1 control wrap");
        stop();

        // R8: alarm B hole and an address in no section
        start(1'b0); set_addr(6'h0C); wbyte(8'h7C); wbyte(8'h77); wbyte(8'h7E);
        set_addr(6'h20); wbyte(8'h55); stop();
        start(1'b1); set_addr(6'h0C);
        rbyte(8'h7C, "R8 alarm B before hole");
        rbyte(8'h00, "R8 alarm B hole");
        rbyte(8'h7E, "R8 alarm B after hole");
        set_addr(6'h20); rbyte(8'h00, "R8 outside sections");
        stop();

        // R5: frozen copy during a read burst across the time wrap
        live_time = T1;
        start(1'b1); set_addr(6'h36);
        rbyte(8'h07, "R5 time byte 6");
        live_time = T2;
        rbyte(8'h08, "R5 time byte 7 frozen");
        rbyte(8'h01, "R1 time wrap frozen");
        rbyte(8'h02, "R5 time byte 1 frozen");
        stop();
        start(1'b1); set_addr(6'h30); rbyte(8'h11, "R5 new copy"); stop();

        // R6: time write staged and applied at stop
        start(1'b0); set_addr(6'h32); wbyte(8'h45); wbyte(8'h12);
        live_time = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        check(time_load == 1'b0, "R6 no early load", 64'(time_load), 64'd0);
        stop_chk(1'b1, 64'h1817_1615_1245_1211, "R6 commit at stop");

        // R9: wrong-direction strobes ignored
        start(1'b0); set_addr(6'h00); rbyte_none("R9 read strobe in write"); stop();
        start(1'b1); set_addr(6'h00); wbyte(8'h99); stop();
        start(1'b1); set_addr(6'h00); rbyte(8'h33, "R9 write strobe in read"); stop();

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R9 all bytes returned", 64'(exp_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule